// File: doc/BRIEF.md
# I2C Slave Transmitter with Event Status Codes

This block is the transmit half of an I2C slave. It watches an oversampled SCL/SDA pair. When a START is followed by its own 7-bit address and a direction bit of 1, it acknowledges the address. It then sends bytes supplied by a host to the master, most significant bit first. A neighbouring receive path can learn of write-direction matches, whether to its own address or to the general-call address, through a one-cycle strobe. This block does not acknowledge writes.

Every point where the host must act is reported as an 8-bit status code, together with a pending-event flag. While the flag is pending the block pulls SCL low, which stalls the master. A host write does four things at once: it clears the flag, supplies the next byte, sets the acknowledge-enable control and releases SCL. If acknowledge-enable is written low together with a byte, that byte is the last one. After the last byte the slave drops off the bus, so a master that keeps reading sees all ones.

The status code 0xB0 replaces 0xA8 when the address match happens while the `arb_lost` input is high. This is the case where a local master lost arbitration and was addressed as a slave in the same cycle.

Top module: `i2c_slv_tx`

## Requirements
- R1: After reset the event flag is 0, `status` reads 0xF8, acknowledge-enable is 0 and neither SCL nor SDA is pulled low.
- R2: START, then own address and direction bit 1, with acknowledge-enable set: the slave pulls SDA low in the ninth clock, then raises the event flag with status 0xA8.
- R3: The same match while `arb_lost` is high reports status 0xB0 instead of 0xA8.
- R4: Data bits go out most significant bit first. SDA changes only while the synchronised SCL is low. SDA is released during the master's acknowledge bit.
- R5: After a byte that was not marked last, a master ACK gives status 0xB8 and the slave waits for the next byte. A master NACK after any byte gives status 0xC0 and returns the slave to the not-addressed state.
- R6: After a byte loaded with acknowledge-enable low, a master ACK gives status 0xC8. The slave then becomes not addressed, so further bytes read as 0xFF and raise no further event.
- R7: While the event flag is set, SCL is pulled low. A host write clears the flag and releases SCL. With no flag pending, `status` reads 0xF8.
- R8: While acknowledge-enable is 0, the slave's own address gets no ACK and raises no event. Once acknowledge-enable is set again, the next START is recognised.
- R9: A write-direction match pulses `wr_match` for one cycle and leaves SDA released. A match counts when the address is the slave's own, or is 0x00 with `gc_en` high, and acknowledge-enable is set. Address 0x00 with `gc_en` low, 0x00 with the read bit, and any foreign address produce neither an ACK nor a pulse.
- R10: A repeated START in the middle of a transfer restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| own_addr | input | 7 | Static own slave address |
| gc_en | input | 1 | Static enable for address 0x00 write matches |
| arb_lost | input | 1 | High while a local master has lost arbitration |
| hst_wr | input | 1 | Host write strobe: clears the flag, loads the byte and acknowledge-enable |
| hst_data | input | 8 | Next byte to transmit |
| hst_ack_en | input | 1 | Acknowledge-enable; 0 marks the loaded byte as last |
| evt_flag | output | 1 | Pending-event flag |
| status | output | 8 | Event status code, 0xF8 when no event is pending |
| wr_match | output | 1 | One-cycle strobe on a write-direction match |

## Verification
The bench drives a bus master whose timing is stretched by the slave. A scoreboard checks the status codes it predicts in order, and the master compares each byte it reads. Multi-byte reads that end in a NACK separate 0xB8 from 0xC0. A last byte that the master still ACKs, followed by one more read, separates 0xC8 from the other codes and shows the all-ones padding. Foreign addresses, address 0x00 with and without `gc_en`, and the read bit with address 0x00 show that only real matches are acknowledged. Reads with acknowledge-enable cleared, reads while `arb_lost` is high, and a write address followed by a repeated START cover address suppression, the 0xB0 path and the restart of address reception.

// File: rtl/i2c_stx_pkg.sv
// Shared constants and types for the I2C slave transmitter.
// Assumes a standard 7-bit address plus direction bit and 8-bit data.
package i2c_stx_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam int CNT_W  = 4;

    // Status codes reported to the host
    typedef enum logic [BYTE_W-1:0] {
        ST_OWN_RD   = 8'hA8,
        ST_ARB_RD   = 8'hB0,
        ST_TX_ACK   = 8'hB8,
        ST_TX_NACK  = 8'hC0,
        ST_LAST_ACK = 8'hC8,
        ST_NONE     = 8'hF8
    } stat_e;

    // Protocol phase of the slave
    typedef enum logic [2:0] {
        P_IDLE,
        P_ADDR,
        P_AACK,
        P_WAIT,
        P_TXD,
        P_MACK
    } phase_e;

    // Bus events decoded from the synchronised lines
    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } busev_t;

endpackage

// File: rtl/i2c_stx_sync.sv
// Multi-stage synchroniser for a group of asynchronous lines.
// Assumes STAGES >= 2; lines reset to 1 (idle bus level).
module i2c_stx_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] pipe [STAGES];

    // Shift the raw levels through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '1;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/i2c_stx_busmon.sv
// Bus monitor: synchronises SCL/SDA, finds clock edges and START/STOP.
// Assumes the system clock is several times faster than SCL.
module i2c_stx_busmon
    import i2c_stx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   scl_i,
    input  logic   sda_i,
    output busev_t ev,
    output logic   scl_lvl
);

    logic [1:0] lines;
    logic       scl_p, sda_p;

    i2c_stx_sync #(.W(2), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_i, sda_i}),
        .q     (lines)
    );

    // Remember the previous synchronised levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= lines[1];
            sda_p <= lines[0];
        end
    end

    // Decode edges and START/STOP conditions
    always_comb begin
        ev.scl_rise = lines[1] & ~scl_p;
        ev.scl_fall = ~lines[1] & scl_p;
        ev.start    = scl_p & lines[1] & sda_p & ~lines[0];
        ev.stop     = scl_p & lines[1] & ~sda_p & lines[0];
        ev.sda      = lines[0];
    end

    assign scl_lvl = lines[1];

endmodule

// File: rtl/i2c_stx_host.sv
// Host side: event flag, latched status, transmit byte and ack-enable.
// Assumes the host writes only to answer an event or to change ack-enable.
module i2c_stx_host
    import i2c_stx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hst_wr,
    input  logic [BYTE_W-1:0] hst_data,
    input  logic              hst_ack_en,
    input  logic              evt,
    input  stat_e             evt_code,
    output logic              flag,
    output logic [BYTE_W-1:0] status,
    output logic              ack_en,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              load
);

    stat_e code_q;

    // Set the flag on events, clear it on a host write, pulse load once
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag    <= 1'b0;
            code_q  <= ST_NONE;
            ack_en  <= 1'b0;
            tx_byte <= '0;
            load    <= 1'b0;
        end else begin
            load <= 1'b0;
            if (evt) begin
                flag   <= 1'b1;
                code_q <= evt_code;
            end else if (hst_wr && flag) begin
                flag <= 1'b0;
                load <= 1'b1;
            end
            if (hst_wr) begin
                tx_byte <= hst_data;
                ack_en  <= hst_ack_en;
            end
        end
    end

    // Report the idle code whenever nothing is pending
    always_comb status = flag ? code_q : ST_NONE;

endmodule

// File: rtl/i2c_stx_fsm.sv
// Protocol engine: address match, address ACK, byte shifting, master ACK.
// Assumes events come from i2c_stx_busmon; SCL is held low by the top
// while an event is pending, so no clock edges arrive in P_WAIT.
module i2c_stx_fsm
    import i2c_stx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  busev_t            ev,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gc_en,
    input  logic              arb_lost,
    input  logic              ack_en,
    input  logic              load,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              sda_drv,
    output logic              evt,
    output stat_e             evt_code,
    output logic              wr_match
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    phase_e            phase;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic              last_q;
    logic              mack;
    logic              own_hit, gc_hit, rd_bit;

    // Decode the received address byte
    always_comb begin
        own_hit = (shreg[BYTE_W-1:1] == own_addr);
        gc_hit  = gc_en && (shreg[BYTE_W-1:1] == '0);
        rd_bit  = shreg[0];
    end

    // Phase sequencing and SDA control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= P_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            last_q   <= 1'b0;
            mack     <= 1'b0;
            sda_drv  <= 1'b0;
            evt      <= 1'b0;
            evt_code <= ST_NONE;
            wr_match <= 1'b0;
        end else begin
            evt      <= 1'b0;
            wr_match <= 1'b0;
            if (ev.stop) begin
                phase   <= P_IDLE;
                sda_drv <= 1'b0;
            end else if (ev.start) begin
                phase   <= P_ADDR;
                bitcnt  <= '0;
                sda_drv <= 1'b0;
            end else begin
                case (phase)
                    P_ADDR: begin
                        if (ev.scl_rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], ev.sda};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (ev.scl_fall && bitcnt == FULL_CNT) begin
                            if (ack_en && own_hit && rd_bit) begin
                                sda_drv  <= 1'b1;
                                phase    <= P_AACK;
                                evt_code <= arb_lost ? ST_ARB_RD : ST_OWN_RD;
                            end else begin
                                phase    <= P_IDLE;
                                wr_match <= ack_en && (own_hit || gc_hit) && !rd_bit;
                            end
                        end
                    end
                    P_AACK: begin
                        if (ev.scl_fall) begin
                            sda_drv <= 1'b0;
                            evt     <= 1'b1;
                            phase   <= P_WAIT;
                        end
                    end
                    P_WAIT: begin
                        if (load) begin
                            shreg   <= tx_byte;
                            last_q  <= !ack_en;
                            sda_drv <= !tx_byte[BYTE_W-1];
                            bitcnt  <= '0;
                            phase   <= P_TXD;
                        end
                    end
                    P_TXD: begin
                        if (ev.scl_fall) begin
                            if (bitcnt == LAST_BIT) begin
                                sda_drv <= 1'b0;
                                phase   <= P_MACK;
                            end else begin
                                shreg   <= {shreg[BYTE_W-2:0], 1'b1};
                                sda_drv <= !shreg[BYTE_W-2];
                                bitcnt  <= bitcnt + 1'b1;
                            end
                        end
                    end
                    P_MACK: begin
                        if (ev.scl_rise) begin
                            mack <= !ev.sda;
                        end else if (ev.scl_fall) begin
                            evt <= 1'b1;
                            if (!mack) begin
                                evt_code <= ST_TX_NACK;
                                phase    <= P_IDLE;
                            end else if (last_q) begin
                                evt_code <= ST_LAST_ACK;
                                phase    <= P_IDLE;
                            end else begin
                                evt_code <= ST_TX_ACK;
                                phase    <= P_WAIT;
                            end
                        end
                    end
                    default: phase <= P_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_slv_tx.sv
// Top of the I2C slave transmitter: bus monitor, protocol engine, host regs.
// Assumes open-drain pads outside: *_oe = 1 pulls the line low.
module i2c_slv_tx
    import i2c_stx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gc_en,
    input  logic              arb_lost,
    input  logic              hst_wr,
    input  logic [BYTE_W-1:0] hst_data,
    input  logic              hst_ack_en,
    output logic              evt_flag,
    output logic [BYTE_W-1:0] status,
    output logic              wr_match
);

    busev_t            ev;
    logic              scl_lvl;
    logic              evt, ack_en, load;
    stat_e             evt_code;
    logic [BYTE_W-1:0] tx_byte;

    i2c_stx_busmon #(.SYNC_STAGES(SYNC_STAGES)) mon_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .ev      (ev),
        .scl_lvl (scl_lvl)
    );

    i2c_stx_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev),
        .own_addr (own_addr),
        .gc_en    (gc_en),
        .arb_lost (arb_lost),
        .ack_en   (ack_en),
        .load     (load),
        .tx_byte  (tx_byte),
        .sda_drv  (sda_oe),
        .evt      (evt),
        .evt_code (evt_code),
        .wr_match (wr_match)
    );

    i2c_stx_host host_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .hst_wr     (hst_wr),
        .hst_data   (hst_data),
        .hst_ack_en (hst_ack_en),
        .evt        (evt),
        .evt_code   (evt_code),
        .flag       (evt_flag),
        .status     (status),
        .ack_en     (ack_en),
        .tx_byte    (tx_byte),
        .load       (load)
    );

    // Stretch SCL while an event is pending and during the reload cycle
    always_comb scl_oe = evt_flag | load;

endmodule

// File: rtl/i2c_stx_chk.sv
// Protocol checker for i2c_slv_tx, attached by bind.
// Assumes synchronous active-low reset on the same clock.
module i2c_stx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       evt_flag,
    input logic [7:0] status,
    input logic       hst_wr,
    input logic       wr_match,
    input logic       scl_lvl
);

    // R7: a pending event always stretches the clock
    a_r7_hold_scl: assert property (@(posedge clk) disable iff (!rst_n)
        evt_flag |-> scl_oe);

    // R7: the flag only drops after a host write
    a_r7_clear_by_host: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(evt_flag) |-> $past(hst_wr));

    // R2, R3, R5, R6: a new event carries one of the defined codes
    a_r2_event_code: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_flag) |-> (status == 8'hA8 || status == 8'hB0 ||
                             status == 8'hB8 || status == 8'hC0 ||
                             status == 8'hC8));

    // R4: the slave changes SDA only while SCL is low
    a_r4_sda_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_lvl));

    // R9: a write match never acknowledges
    a_r9_wr_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        wr_match |=> !sda_oe);

endmodule

bind i2c_slv_tx i2c_stx_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .evt_flag (evt_flag),
    .status   (status),
    .hst_wr   (hst_wr),
    .wr_match (wr_match),
    .scl_lvl  (scl_lvl)
);

// File: tb/i2c_slv_tx_tb_top.sv
// Scoreboard bench: a bus master task set plus a host responder that pops
// expected events from a queue and answers them.
module i2c_slv_tx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HB         = 8;
    localparam logic [6:0] OWN = 7'h5B;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       scl_oe, sda_oe, evt_flag, wr_match;
    logic [7:0] status;
    logic       gc_en = 1'b0, arb_lost = 1'b0;
    logic       hst_wr = 1'b0, hst_ack_en = 1'b0;
    logic [7:0] hst_data = 8'h00;
    logic       scl_bus, sda_bus;

    assign scl_bus = scl_m & ~scl_oe;
    assign sda_bus = sda_m & ~sda_oe;

    i2c_slv_tx dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_bus),
        .sda_i      (sda_bus),
        .scl_oe     (scl_oe),
        .sda_oe     (sda_oe),
        .own_addr   (OWN),
        .gc_en      (gc_en),
        .arb_lost   (arb_lost),
        .hst_wr     (hst_wr),
        .hst_data   (hst_data),
        .hst_ack_en (hst_ack_en),
        .evt_flag   (evt_flag),
        .status     (status),
        .wr_match   (wr_match)
    );

    int n_chk = 0;
    int n_bad = 0;
    int wr_cnt = 0;

    typedef struct {
        logic [7:0] code;
        logic [7:0] data;
        logic       ack_en;
        string      req;
    } item_t;
    item_t sb_q[$];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver side of the scoreboard: record an expected event and its answer
    task automatic expect_evt(input logic [7:0] code, input logic [7:0] data,
                              input logic ack_en, input string req);
        item_t it;
        it.code = code; it.data = data; it.ack_en = ack_en; it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic host_write(input logic [7:0] d, input logic ae);
        hst_data = d; hst_ack_en = ae; hst_wr = 1'b1;
        @(negedge clk);
        hst_wr = 1'b0;
    endtask

    task automatic scl_up();
        scl_m = 1'b1;
        while (scl_bus !== 1'b1) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; wt(HB); scl_up(); wt(HB);
        sda_m = 1'b0; wt(HB); scl_m = 1'b0; wt(HB);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; wt(HB); scl_up(); wt(HB);
        sda_m = 1'b1; wt(HB);
    endtask

    task automatic m_wbit(input logic b);
        sda_m = b; wt(HB); scl_up(); wt(HB); scl_m = 1'b0; wt(HB);
    endtask

    task automatic m_rbit(output logic b);
        sda_m = 1'b1; wt(HB); scl_up(); wt(HB/2);
        b = sda_bus; wt(HB/2); scl_m = 1'b0; wt(HB);
    endtask

    task automatic m_addr(input logic [6:0] a, input logic rw, input logic exp_ack,
                          input string req);
        logic b;
        for (int i = 6; i >= 0; i--) m_wbit(a[i]);
        m_wbit(rw);
        m_rbit(b);
        chk(req, b, exp_ack);
    endtask

    task automatic m_rbyte(input logic [7:0] exp, input logic nack, input string req);
        logic [7:0] got;
        logic b;
        for (int i = 7; i >= 0; i--) begin
            m_rbit(b);
            got[i] = b;
        end
        chk(req, got, exp);
        sda_m = nack; wt(HB); scl_up(); wt(HB/2);
        chk("R4 SDA released in master ack bit", sda_oe, 1'b0);
        wt(HB/2); scl_m = 1'b0; wt(HB);
    endtask

    // Write-match strobe counter
    always @(posedge clk) if (rst_n && wr_match) wr_cnt++;

    // Monitor side of the scoreboard: compare and answer each event
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && evt_flag) begin
                if (sb_q.size() == 0) begin
                    chk("R6 R8 no event expected", status, 8'hF8);
                    host_write(8'h00, 1'b1);
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    chk(it.req, status, it.code);
                    wt(6);
                    chk("R7 SCL stretched while flag set", scl_oe, 1'b1);
                    host_write(it.data, it.ack_en);
                    wt(3);
                    chk("R7 flag cleared by host write", evt_flag, 1'b0);
                    chk("R7 status idle code", status, 8'hF8);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Stimulus
    initial begin
        int w0;
        wt(5);
        rst_n = 1'b1;
        wt(3);
        chk("R1 flag after reset", evt_flag, 1'b0);
        chk("R1 status after reset", status, 8'hF8);
        chk("R1 lines released", {scl_oe, sda_oe}, 2'b00);
        // ack-enable is still 0 after reset: own read must be ignored
        m_start();
        m_addr(OWN, 1'b1, 1'b1, "R1 no ack before enable");
        m_stop();

        host_write(8'h00, 1'b1);

        // Two bytes: ACK then NACK
        expect_evt(8'hA8, 8'hA5, 1'b1, "R2 own read status");
        expect_evt(8'hB8, 8'h3C, 1'b0, "R5 ack status");
        expect_evt(8'hC0, 8'h00, 1'b1, "R5 nack status");
        m_start();
        m_addr(OWN, 1'b1, 1'b0, "R2 address ack");
        m_rbyte(8'hA5, 1'b0, "R4 first byte");
        m_rbyte(8'h3C, 1'b1, "R4 second byte");
        m_stop();

        // Last byte acknowledged by master, then padding
        expect_evt(8'hA8, 8'h81, 1'b0, "R2 own read status");
        expect_evt(8'hC8, 8'h00, 1'b1, "R6 last ack status");
        m_start();
        m_addr(OWN, 1'b1, 1'b0, "R2 address ack");
        m_rbyte(8'h81, 1'b0, "R4 last byte");
        m_rbyte(8'hFF, 1'b1, "R6 padding all ones");
        chk("R6 no event after padding", evt_flag, 1'b0);
        m_stop();

        // Foreign address
        m_start();
        m_addr(OWN ^ 7'h01, 1'b1, 1'b1, "R9 foreign address nack");
        m_stop();
        chk("R9 no event on foreign address", evt_flag, 1'b0);

        // ack-enable low, then restored
        host_write(8'h00, 1'b0);
        m_start();
        m_addr(OWN, 1'b1, 1'b1, "R8 own address ignored");
        m_stop();
        chk("R8 no event while disabled", evt_flag, 1'b0);
        host_write(8'h00, 1'b1);
        expect_evt(8'hA8, 8'hE7, 1'b0, "R8 recognition restored");
        expect_evt(8'hC0, 8'h00, 1'b1, "R5 nack status");
        m_start();
        m_addr(OWN, 1'b1, 1'b0, "R8 ack after re-enable");
        m_rbyte(8'hE7, 1'b1, "R4 byte after re-enable");
        m_stop();

        // Arbitration lost
        arb_lost = 1'b1;
        expect_evt(8'hB0, 8'h5A, 1'b0, "R3 arbitration lost status");
        expect_evt(8'hC0, 8'h00, 1'b1, "R5 nack status");
        m_start();
        m_addr(OWN, 1'b1, 1'b0, "R3 address ack");
        arb_lost = 1'b0;
        m_rbyte(8'h5A, 1'b1, "R3 byte after arbitration loss");
        m_stop();

        // Write-direction matches
        w0 = wr_cnt;
        m_start();
        m_addr(OWN, 1'b0, 1'b1, "R9 own write not acked");
        m_stop();
        chk("R9 own write strobe", wr_cnt - w0, 1);
        w0 = wr_cnt;
        m_start();
        m_addr(7'h00, 1'b0, 1'b1, "R9 gc disabled not acked");
        m_stop();
        chk("R9 gc ignored when disabled", wr_cnt - w0, 0);
        gc_en = 1'b1;
        w0 = wr_cnt;
        m_start();
        m_addr(7'h00, 1'b0, 1'b1, "R9 gc write not acked");
        m_stop();
        chk("R9 gc write strobe", wr_cnt - w0, 1);
        w0 = wr_cnt;
        m_start();
        m_addr(7'h00, 1'b1, 1'b1, "R9 gc read not acked");
        m_stop();
        chk("R9 gc read no strobe", wr_cnt - w0, 0);
        chk("R9 gc read no event", evt_flag, 1'b0);
        gc_en = 1'b0;

        // Repeated START after a write address
        expect_evt(8'hA8, 8'hC3, 1'b0, "R10 status after repeated start");
        expect_evt(8'hC0, 8'h00, 1'b1, "R5 nack status");
        m_start();
        m_addr(OWN ^ 7'h10, 1'b0, 1'b1, "R10 first address ignored");
        m_start();
        m_addr(OWN, 1'b1, 1'b0, "R10 address ack after repeated start");
        m_rbyte(8'hC3, 1'b1, "R10 byte after repeated start");
        m_stop();

        wt(20);
        chk("R7 scoreboard drained", sb_q.size(), 0);
        chk("R7 final status idle", status, 8'hF8);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule